// File: doc/BRIEF.md
# Bit-Serial Rank Selector

The block picks the k-th smallest of N unsigned operands. The operands are never stored. Every lane carries one operand, one bit per clock, most significant bit first, and all lanes move together as one bit-plane per valid strobe. Each lane has a live flag. On each bit-plane a combinational adder tree counts the ones among the live lanes. The root then decides whether the wanted operand lies among the live lanes with a zero bit or among those with a one bit. It clears the flags of the other side and updates the number of survivors and the rank that is still sought.

A run begins with a start pulse carrying the rank k (1 ≤ k ≤ N). It ends when exactly one lane survives, or when all WIDTH bit-planes have been consumed. In the second case the lowest-numbered survivor is reported, so equal operands resolve toward the smaller lane index. On completion the block gives a one-cycle done pulse and holds the winning lane index until the next completion.

Top module: `kth_select_top`

## Requirements
- R1: After reset, done_o is 0 and index_o is 0, and the block stays idle until a start pulse arrives.
- R2: A start pulse makes every lane live, sets the survivor count to N and the sought rank to rank_i, and begins a new run. This also applies while a run is in progress. A bit-plane presented in the same cycle as start is not used.
- R3: While running, each cycle with bits_vld_i high consumes one bit-plane. bit i of bits_i is the current bit of lane i. Lanes that are no longer live contribute nothing.
- R4: If the number of live lanes with a 0 bit is at least the sought rank, the live lanes with a 1 bit drop out and the survivor count becomes that zero count.
- R5: Otherwise, the live lanes with a 0 bit drop out, the sought rank is reduced by the zero count, and the survivor count becomes the one count.
- R6: When a bit-plane leaves exactly one survivor, done_o pulses in the cycle after that bit-plane is accepted, and index_o gives that lane.
- R7: If WIDTH bit-planes have been consumed without a single survivor, done_o pulses after the last bit-plane, and index_o gives the lowest-numbered live lane. Equal operands therefore resolve to the smallest index.
- R8: done_o lasts one cycle. index_o holds its value until the next completion. Bit-planes presented after completion and before a new start have no effect.
- R9: A running cycle with bits_vld_i low changes neither the live flags nor the rank state. Gaps in the stream are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new selection |
| rank_i | input | $clog2(LANES)+1 | Rank k, sampled with start_i |
| bits_i | input | LANES | Current bit of every lane, MSB-first stream |
| bits_vld_i | input | 1 | bits_i holds a bit-plane |
| done_o | output | 1 | One-cycle completion pulse |
| index_o | output | $clog2(LANES) | Index of the selected lane |

## Verification
A restart can arrive in the same cycle as a valid bit-plane of the run it replaces. The bench provokes this by raising start_i with junk bits and bits_vld_i high partway through a run. It then judges from the later index and from the cycle in which done arrives that the junk plane was discarded and the new run counted from N. A second overlap is stream gaps falling next to the last bit-plane. Idle cycles are inserted at random between bit-planes, and the completion cycle must still match the plane count derived from prefix uniqueness.

// File: rtl/ksel_pkg.sv
package ksel_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ksel_state_e;
endpackage

// File: rtl/ksel_popcount.sv
module ksel_popcount #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]         bits_i,
  output logic [$clog2(LANES):0]   sum_o
);
  localparam int CNTW  = $clog2(LANES) + 1;
  localparam int NODES = 2 * LANES - 1;

  // heap layout: node n has children 2n+1 and 2n+2, leaves at LANES-1 and up
  logic [CNTW-1:0] node [NODES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_leaf
      assign node[LANES-1+g] = CNTW'(bits_i[g]);
    end
    for (g = 0; g < LANES - 1; g++) begin : g_add
      assign node[g] = node[2*g+1] + node[2*g+2];
    end
  endgenerate

  assign sum_o = node[0];
endmodule

// File: rtl/ksel_leaf_bank.sv
module ksel_leaf_bank #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             apply_i,
  input  logic             keep_ones_i,
  input  logic [LANES-1:0] bits_i,
  output logic [LANES-1:0] live_o,
  output logic [LANES-1:0] live_next_o
);
  logic [LANES-1:0] live_q;
  logic [LANES-1:0] live_d;
  logic             live_en;

  always_comb begin
    live_d  = live_q;
    live_en = clear_i | apply_i;
    if (clear_i) begin
      live_d = '1;
    end else if (apply_i) begin
      live_d = live_q & (keep_ones_i ? bits_i : ~bits_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '1;
    end else if (live_en) begin
      live_q <= live_d;
    end
  end

  assign live_o      = live_q;
  assign live_next_o = live_d;
endmodule

// File: rtl/ksel_low_enc.sv
module ksel_low_enc #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]         req_i,
  output logic [$clog2(LANES)-1:0] idx_o
);
  localparam int IDXW = $clog2(LANES);

  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i);
    end
  end
endmodule

// File: rtl/ksel_root.sv
module ksel_root
  import ksel_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [$clog2(LANES):0]   rank_i,
  input  logic                     bits_vld_i,
  input  logic [$clog2(LANES):0]   ones_i,
  input  logic [$clog2(LANES)-1:0] low_idx_i,
  output logic                     apply_o,
  output logic                     keep_ones_o,
  output logic                     done_o,
  output logic [$clog2(LANES)-1:0] index_o,
  output logic [$clog2(LANES):0]   cnt_o,
  output logic [$clog2(LANES):0]   rank_o,
  output logic                     busy_o
);
  localparam int IDXW = $clog2(LANES);
  localparam int CNTW = IDXW + 1;
  localparam int PLW  = $clog2(WIDTH + 1);

  ksel_state_e     state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW-1:0] rank_q, rank_d;
  logic [PLW-1:0]  plane_q, plane_d;
  logic            done_q, done_d;
  logic [IDXW-1:0] index_q, index_d;

  logic [CNTW-1:0] zeros;
  logic            go_zero;
  logic            take;
  logic            last_plane;
  logic            finish;
  logic            ctl_en;

  assign zeros      = cnt_q - ones_i;
  assign go_zero    = (zeros >= rank_q);
  assign take       = (state_q == ST_RUN) && bits_vld_i && !start_i;
  assign last_plane = (plane_q == PLW'(WIDTH - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rank_d  = rank_q;
    plane_d = plane_q;
    finish  = 1'b0;
    if (start_i) begin
      state_d = ST_RUN;
      cnt_d   = CNTW'(LANES);
      rank_d  = rank_i;
      plane_d = '0;
    end else if (take) begin
      plane_d = plane_q + PLW'(1);
      if (go_zero) begin
        cnt_d = zeros;
      end else begin
        cnt_d  = ones_i;
        rank_d = rank_q - zeros;
      end
      finish = (cnt_d == CNTW'(1)) || last_plane;
      if (finish) state_d = ST_IDLE;
    end
  end

  assign ctl_en  = start_i | take;
  assign done_d  = finish;
  assign index_d = finish ? low_idx_i : index_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= CNTW'(LANES);
      rank_q  <= CNTW'(1);
      plane_q <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rank_q  <= rank_d;
      plane_q <= plane_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      index_q <= '0;
    end else begin
      done_q  <= done_d;
      index_q <= index_d;
    end
  end

  assign apply_o     = take;
  assign keep_ones_o = !go_zero;
  assign done_o      = done_q;
  assign index_o     = index_q;
  assign cnt_o       = cnt_q;
  assign rank_o      = rank_q;
  assign busy_o      = (state_q == ST_RUN);
endmodule

// File: rtl/kth_select_top.sv
module kth_select_top #(
  parameter int LANES = 8,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [$clog2(LANES):0]   rank_i,
  input  logic [LANES-1:0]         bits_i,
  input  logic                     bits_vld_i,
  output logic                     done_o,
  output logic [$clog2(LANES)-1:0] index_o
);
  localparam int IDXW = $clog2(LANES);
  localparam int CNTW = IDXW + 1;

  logic [LANES-1:0] live_q;
  logic [LANES-1:0] live_next;
  logic [LANES-1:0] live_bits;
  logic [CNTW-1:0]  ones;
  logic [IDXW-1:0]  low_idx;
  logic             apply;
  logic             keep_ones;
  logic [CNTW-1:0]  cnt_w;
  logic [CNTW-1:0]  rank_w;
  logic             busy_w;

  assign live_bits = bits_i & live_q;

  ksel_leaf_bank #(.LANES(LANES)) u_leaves (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_i),
    .apply_i    (apply),
    .keep_ones_i(keep_ones),
    .bits_i     (bits_i),
    .live_o     (live_q),
    .live_next_o(live_next)
  );

  ksel_popcount #(.LANES(LANES)) u_count (
    .bits_i(live_bits),
    .sum_o (ones)
  );

  ksel_low_enc #(.LANES(LANES)) u_enc (
    .req_i(live_next),
    .idx_o(low_idx)
  );

  ksel_root #(.LANES(LANES), .WIDTH(WIDTH)) u_root (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rank_i     (rank_i),
    .bits_vld_i (bits_vld_i),
    .ones_i     (ones),
    .low_idx_i  (low_idx),
    .apply_o    (apply),
    .keep_ones_o(keep_ones),
    .done_o     (done_o),
    .index_o    (index_o),
    .cnt_o      (cnt_w),
    .rank_o     (rank_w),
    .busy_o     (busy_w)
  );
endmodule

// File: rtl/ksel_checker.sv
module ksel_checker #(
  parameter int LANES = 8,
  parameter int WIDTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic [$clog2(LANES):0]   rank_i,
  input logic                     bits_vld_i,
  input logic                     done_o,
  input logic [$clog2(LANES)-1:0] index_o,
  input logic [LANES-1:0]         live_q,
  input logic [$clog2(LANES):0]   cnt_w,
  input logic [$clog2(LANES):0]   rank_w,
  input logic                     busy_w
);
  localparam int CNTW = $clog2(LANES) + 1;

  assert_start_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (live_q == {LANES{1'b1}}) && (cnt_w == CNTW'(LANES)) && (rank_w == $past(rank_i)));

  assert_live_only_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((live_q & ~$past(live_q)) == '0));

  // survivor counter (root) agrees with the flag vector (leaf bank): R4, R5
  assert_count_tracks_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w == CNTW'($countones(live_q)));

  assert_rank_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> (rank_w >= CNTW'(1)) && (rank_w <= cnt_w));

  assert_done_points_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> live_q[index_o]);

  assert_done_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((live_q & ~({LANES{1'b1}} << index_o)) == '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !bits_vld_i && !start_i) |=> ($stable(live_q) && $stable(rank_w) && $stable(cnt_w)));
endmodule

bind kth_select_top ksel_checker #(.LANES(LANES), .WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rank_i    (rank_i),
  .bits_vld_i(bits_vld_i),
  .done_o    (done_o),
  .index_o   (index_o),
  .live_q    (live_q),
  .cnt_w     (cnt_w),
  .rank_w    (rank_w),
  .busy_w    (busy_w)
);

// File: tb/kth_select_top_tb_top.sv
module kth_select_top_tb_top;
  localparam int LANES   = 8;
  localparam int WIDTH   = 8;
  localparam int IDXW    = $clog2(LANES);
  localparam int CNTW    = IDXW + 1;
  localparam int CLK_PER = 10;
  localparam int WD_MAX  = 100000;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [CNTW-1:0]  rank_i;
  logic [LANES-1:0] bits_i;
  logic             bits_vld_i;
  logic             done_o;
  logic [IDXW-1:0]  index_o;

  int checks;
  int fails;
  logic [WIDTH-1:0] vals [LANES];

  kth_select_top #(.LANES(LANES), .WIDTH(WIDTH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rank_i    (rank_i),
    .bits_i    (bits_i),
    .bits_vld_i(bits_vld_i),
    .done_o    (done_o),
    .index_o   (index_o)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lowest lane holding the k-th smallest value
  function automatic int exp_index(input int k);
    for (int i = 0; i < LANES; i++) begin
      int lt = 0;
      int le = 0;
      for (int j = 0; j < LANES; j++) begin
        if (vals[j] < vals[i]) lt++;
        if (vals[j] <= vals[i]) le++;
      end
      if (lt < k && le >= k) return i;
    end
    return -1;
  endfunction

  // bit-plane after which only the target's prefix class remains as a singleton
  function automatic int exp_planes(input int tgt);
    for (int p = 1; p <= WIDTH; p++) begin
      int same = 0;
      for (int j = 0; j < LANES; j++)
        if ((vals[j] >> (WIDTH - p)) == (vals[tgt] >> (WIDTH - p))) same++;
      if (same == 1) return p;
    end
    return WIDTH;
  endfunction

  function automatic logic [LANES-1:0] plane(input int p);
    logic [LANES-1:0] r;
    for (int j = 0; j < LANES; j++) r[j] = vals[j][WIDTH-1-p];
    return r;
  endfunction

  task automatic pulse_start(input int k);
    @(negedge clk);
    start_i    = 1'b1;
    rank_i     = CNTW'(k);
    bits_vld_i = 1'b0;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  // feeds planes until done; returns plane count at done (0 if none)
  task automatic feed(input int gap_pct, output int seen);
    seen = 0;
    for (int p = 0; p < WIDTH; p++) begin
      while (($urandom % 100) < gap_pct) begin
        bits_i     = LANES'($urandom);
        bits_vld_i = 1'b0;
        @(negedge clk);
      end
      bits_i     = plane(p);
      bits_vld_i = 1'b1;
      @(posedge clk);
      #1;
      bits_vld_i = 1'b0;
      if (done_o) begin
        seen = p + 1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int k, input int gap_pct, input string tag);
    int seen;
    int ei;
    int held;
    ei = exp_index(k);
    pulse_start(k);
    feed(gap_pct, seen);
    check({tag, " R6 R7 done plane"}, seen, exp_planes(ei));
    check({tag, " R3 R4 R5 index"}, int'(index_o), ei);
    held = int'(index_o);
    @(posedge clk);
    #1;
    check("R8 done one cycle", int'(done_o), 0);
    // plane after completion must be ignored
    @(negedge clk);
    bits_i     = ~bits_i;
    bits_vld_i = 1'b1;
    @(negedge clk);
    bits_vld_i = 1'b0;
    @(posedge clk);
    #1;
    check("R8 idle plane no done", int'(done_o), 0);
    check("R8 index held", int'(index_o), held);
  endtask

  initial begin : watchdog
    for (int c = 0; c < WD_MAX; c++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int seen;
    checks = 0;
    fails  = 0;
    void'($urandom(32'h1d2c3b4a));
    rst_n = 1'b0;
    start_i = 1'b0;
    rank_i = '0;
    bits_i = '0;
    bits_vld_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset index", int'(index_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: planes before any start do nothing
    bits_i = 8'hff;
    bits_vld_i = 1'b1;
    repeat (3) @(negedge clk);
    bits_vld_i = 1'b0;
    check("R1 idle no done", int'(done_o), 0);

    // distinct values, median rank
    vals = '{8'h0f, 8'h0e, 8'h0c, 8'h03, 8'h07, 8'h06, 8'h0d, 8'h01};
    run_case(4, 0, "directed mid");
    run_case(1, 0, "directed k=1");
    run_case(LANES, 30, "directed k=N gaps R9");
    // all equal: ties to lowest lane, full width consumed
    vals = '{8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55};
    run_case(5, 0, "ties all equal");
    // duplicates split across the rank
    vals = '{8'h90, 8'h10, 8'h90, 8'h10, 8'hff, 8'h00, 8'h90, 8'h10};
    run_case(3, 0, "dups low");
    run_case(5, 20, "dups high");

    // R2: restart overlapping a valid junk plane mid-run
    vals = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01};
    pulse_start(2);
    bits_i = plane(0);
    bits_vld_i = 1'b1;
    @(negedge clk);
    bits_i = plane(1);
    @(negedge clk);
    vals = '{8'h33, 8'h81, 8'h7f, 8'h81, 8'h02, 8'hc0, 8'h33, 8'h44};
    start_i = 1'b1;
    rank_i = CNTW'(6);
    bits_i = 8'hff;
    bits_vld_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    bits_vld_i = 1'b0;
    feed(0, seen);
    check("R2 restart done plane", seen, exp_planes(exp_index(6)));
    check("R2 restart index", int'(index_o), exp_index(6));

    // random runs
    for (int r = 0; r < 60; r++) begin
      for (int j = 0; j < LANES; j++)
        vals[j] = (r % 3 == 0) ? WIDTH'($urandom % 4) : WIDTH'($urandom);
      run_case(1 + int'($urandom % LANES), (r % 2) * 25, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule